// File: doc/BRIEF.md
# VME Slave Address Window and Modifier Decoder

This block decides, once per bus cycle, whether a memory board on a VME backplane is being addressed. When the address strobe goes active it takes the address bits above the 256 KB boundary and checks whether they fall inside a window. The window is bounded below by a start value, which is included, and above by the first address past the board, which is excluded. At the same moment it checks the 6-bit address modifier against ten codes, each with its own enable. The combined decision is registered and held until the strobe is released.

Cycles that use a standard (24-bit) modifier carry no meaningful upper address byte. The block therefore treats that byte as all ones before comparing, so one window configured with a top byte of 0xFF serves both address widths. A configuration bit turns 24-bit decoding off. A test bit accepts any modifier code. A run/local input takes the board off the bus without disturbing anything else. A select indicator follows the select signal and stays lit for a fixed number of cycles after it drops, so that short accesses remain visible.

Top module: `vme_slave_window`

## Requirements
- R1: With a full-width modifier, the board is selected only when address bits 31..18 are greater than or equal to `cfg_start` and strictly less than `cfg_limit`, both compared as unsigned 14-bit values.
- R2: The modifier codes 0x39, 0x3A, 0x3D and 0x3E are 24-bit cycles. For these cycles, address bits 31..24 are replaced by 0xFF before the window compare, and bits 23..18 are used unchanged.
- R3: When `cfg_a24_en` is 0, a 24-bit cycle (0x39, 0x3A, 0x3D, 0x3E) never selects the board, even with `cfg_any_am` set. Full-width cycles are unaffected.
- R4: Each enable bit of `cfg_am_en` admits exactly one code, as follows: bit0=0x3E, bit1=0x3D, bit2=0x3A, bit3=0x39, bit4=0x0E, bit5=0x0D, bit6=0x0A, bit7=0x09, bit8=0x10, bit9=0x11. A listed code whose bit is 0 is rejected.
- R5: With `cfg_any_am` at 0, every code outside the ten listed codes is rejected regardless of `cfg_am_en`. This includes short I/O (0x29, 0x2D) and block transfer (0x0B, 0x0F, 0x3B, 0x3F).
- R6: With `cfg_any_am` at 1, any modifier code is admitted. Codes outside the four 24-bit codes are decoded as full-width.
- R7: While `run` is 0, `sel` is 0 at the clock after `run` was sampled low, and no strobe selects the board.
- R8: `sel` takes its value at the first clock edge at which `as_n` is sampled low. It then holds that value while `as_n` stays low, even if the address or modifier changes. It is 0 at the clock after `as_n` is sampled high.
- R9: When `cfg_limit` is less than or equal to `cfg_start`, no address selects the board.
- R10: `sel_led` is 1 whenever `sel` is 1, and for exactly `LED_HOLD` clock cycles after `sel` falls. It is 0 otherwise.
- R11: While `rst_n` is low, `sel` and `sel_led` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe, active low |
| adr | input | AW-GRAN (14) | Bus address bits 31..18 |
| am | input | 6 | Address modifier code |
| cfg_start | input | AW-GRAN (14) | First selected 256 KB block |
| cfg_limit | input | AW-GRAN (14) | First block not on the board |
| cfg_am_en | input | 10 | Per-code modifier enables |
| cfg_a24_en | input | 1 | Allow 24-bit cycles |
| cfg_any_am | input | 1 | Test mode: admit any modifier |
| run | input | 1 | 1 = on the bus, 0 = local |
| sel | output | 1 | Board selected for this strobe |
| sel_led | output | 1 | Select indicator with hold-off |

## Verification
The assertions assume that the configuration inputs are quasi-static. They also assume that the address and modifier are valid at the clock edge where the strobe is first seen low. The window and modifier properties are written for the edge at which `sel` is still 0, because a latched select is allowed to survive later input changes. The stimulus changes configuration only between strobes, with at least one idle cycle in between. Address and modifier move during an active strobe only in the hold test, and only after the select has been latched.

// File: rtl/vme_slave_window.sv
module vme_slave_window #(
  parameter int AW       = 32,
  parameter int GRAN     = 18,
  parameter int LED_HOLD = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               as_n,
  input  logic [AW-1:GRAN]   adr,
  input  logic [5:0]         am,
  input  logic [AW-GRAN-1:0] cfg_start,
  input  logic [AW-GRAN-1:0] cfg_limit,
  input  logic [9:0]         cfg_am_en,
  input  logic               cfg_a24_en,
  input  logic               cfg_any_am,
  input  logic               run,
  output logic               sel,
  output logic               sel_led
);
  localparam int BW = AW - GRAN;
  localparam int HI = AW - 24;
  localparam int CW = $clog2(LED_HOLD + 1);

  logic          am_ok, am_short;
  logic [BW-1:0] eff;
  logic          hit;
  logic          sel_q, lat_q;
  logic [CW-1:0] led_cnt;

  always_comb begin
    am_short = 1'b0;
    am_ok    = 1'b0;
    unique case (am)
      6'h3E: begin am_ok = cfg_am_en[0]; am_short = 1'b1; end
      6'h3D: begin am_ok = cfg_am_en[1]; am_short = 1'b1; end
      6'h3A: begin am_ok = cfg_am_en[2]; am_short = 1'b1; end
      6'h39: begin am_ok = cfg_am_en[3]; am_short = 1'b1; end
      6'h0E: am_ok = cfg_am_en[4];
      6'h0D: am_ok = cfg_am_en[5];
      6'h0A: am_ok = cfg_am_en[6];
      6'h09: am_ok = cfg_am_en[7];
      6'h10: am_ok = cfg_am_en[8];
      6'h11: am_ok = cfg_am_en[9];
      default: am_ok = 1'b0;
    endcase
    if (cfg_any_am) am_ok = 1'b1;
    if (am_short && !cfg_a24_en) am_ok = 1'b0;
  end

  assign eff = am_short ? {{HI{1'b1}}, adr[23:GRAN]} : adr;
  assign hit = am_ok && (eff >= cfg_start) && (eff < cfg_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      lat_q <= !as_n;
      if (as_n || !run)  sel_q <= 1'b0;
      else if (!lat_q)   sel_q <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              led_cnt <= '0;
    else if (sel_q)          led_cnt <= CW'(LED_HOLD);
    else if (led_cnt != '0)  led_cnt <= led_cnt - 1'b1;
  end

  assign sel     = sel_q;
  assign sel_led = sel_q || (led_cnt != '0);
endmodule

// File: rtl/vme_slave_window_chk.sv
module vme_slave_window_chk #(
  parameter int AW       = 32,
  parameter int GRAN     = 18,
  parameter int LED_HOLD = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               as_n,
  input logic [AW-1:GRAN]   adr,
  input logic [5:0]         am,
  input logic [AW-GRAN-1:0] cfg_start,
  input logic [AW-GRAN-1:0] cfg_limit,
  input logic [9:0]         cfg_am_en,
  input logic               cfg_a24_en,
  input logic               cfg_any_am,
  input logic               run,
  input logic               sel,
  input logic               sel_led
);
  localparam int CW = $clog2(LED_HOLD + 1);
  logic [CW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)                    since <= CW'(LED_HOLD);
    else if (sel)                  since <= '0;
    else if (since != CW'(LED_HOLD)) since <= since + 1'b1;
  end

  // R1
  above_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !as_n && am == 6'h09 && adr >= cfg_limit) |=> !sel);
  // R1
  below_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !as_n && am == 6'h0D && adr < cfg_start) |=> !sel);
  // R3
  a24_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !cfg_a24_en && (am == 6'h39 || am == 6'h3A || am == 6'h3D || am == 6'h3E)) |=> !sel);
  // R4
  code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !cfg_any_am && am == 6'h3E && !cfg_am_en[0]) |=> !sel);
  // R5
  short_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !cfg_any_am && (am == 6'h2D || am == 6'h29 || am == 6'h3F || am == 6'h0F)) |=> !sel);
  // R7
  local_chk: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !sel);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n) as_n |=> !sel);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !as_n && run) |=> sel);
  // R9
  empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && cfg_limit <= cfg_start) |=> !sel);
  // R10
  led_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel || since < CW'(LED_HOLD)) |-> sel_led);
  // R10
  led_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && since >= CW'(LED_HOLD)) |-> !sel_led);
endmodule

bind vme_slave_window vme_slave_window_chk #(.AW(AW), .GRAN(GRAN), .LED_HOLD(LED_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .adr(adr), .am(am),
  .cfg_start(cfg_start), .cfg_limit(cfg_limit), .cfg_am_en(cfg_am_en),
  .cfg_a24_en(cfg_a24_en), .cfg_any_am(cfg_any_am), .run(run),
  .sel(sel), .sel_led(sel_led));

// File: tb/vme_slave_window_bench.sv
module vme_slave_window_bench;
  localparam int LED_HOLD = 8;

  logic        clk = 0, rst_n = 0, as_n = 1, run = 1;
  logic [31:0] addr = 0;
  logic [5:0]  am = 6'h09;
  logic [13:0] cfg_start = 14'h3FC4, cfg_limit = 14'h3FC8;
  logic [9:0]  cfg_am_en = 10'h0FF;
  logic        cfg_a24_en = 1, cfg_any_am = 0;
  logic        sel, sel_led;

  int errors = 0, checks = 0;
  string tag = "R11";
  bit started = 0;

  always #5 clk = ~clk;

  vme_slave_window #(.AW(32), .GRAN(18), .LED_HOLD(LED_HOLD)) u_vme_slave_window (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .adr(addr[31:18]), .am(am),
    .cfg_start(cfg_start), .cfg_limit(cfg_limit), .cfg_am_en(cfg_am_en),
    .cfg_a24_en(cfg_a24_en), .cfg_any_am(cfg_any_am), .run(run),
    .sel(sel), .sel_led(sel_led));

  function automatic bit ref_match(logic [31:0] a, logic [5:0] m);
    logic [5:0] codes [10] = '{6'h3E, 6'h3D, 6'h3A, 6'h39, 6'h0E, 6'h0D, 6'h0A, 6'h09, 6'h10, 6'h11};
    bit ok = cfg_any_am;
    bit narrow = (m == 6'h39 || m == 6'h3A || m == 6'h3D || m == 6'h3E);
    logic [31:0] ea;
    for (int i = 0; i < 10; i++) if (codes[i] == m && cfg_am_en[i]) ok = 1;
    if (narrow && !cfg_a24_en) ok = 0;
    ea = narrow ? {8'hFF, a[23:0]} : a;
    return ok && ({14'b0, ea[31:18]} >= {14'b0, cfg_start}) && ({14'b0, ea[31:18]} < {14'b0, cfg_limit});
  endfunction

  bit r_sel = 0, r_in = 0;
  int r_hold = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      r_sel <= 0; r_in <= 0; r_hold <= 0;
    end else begin
      r_in <= !as_n;
      if (as_n || !run) r_sel <= 0;
      else if (!r_in)   r_sel <= ref_match(addr, am);
      if (r_sel) r_hold <= LED_HOLD;
      else if (r_hold > 0) r_hold <= r_hold - 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(sel == r_sel, tag, sel, r_sel);
    chk(sel_led == (r_sel || r_hold > 0), tag, sel_led, (r_sel || r_hold > 0));
  end

  task automatic access(logic [31:0] a, logic [5:0] m, bit exp, string req);
    @(posedge clk); #3; addr = a; am = m; as_n = 0; tag = req;
    @(posedge clk); @(negedge clk);
    chk(sel == exp, req, sel, exp);
    @(posedge clk); #3; addr = ~a; am = 6'h2D;
    @(posedge clk); @(negedge clk);
    chk(sel == exp, {req, "/R8 hold"}, sel, exp);
    @(posedge clk); #3; as_n = 1;
    @(posedge clk); @(negedge clk);
    chk(sel == 0, "R8 release", sel, 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [5:0] codes [10] = '{6'h3E, 6'h3D, 6'h3A, 6'h39, 6'h0E, 6'h0D, 6'h0A, 6'h09, 6'h10, 6'h11};
    int n;
    repeat (3) @(negedge clk);
    chk(sel == 0, "R11", sel, 0);
    chk(sel_led == 0, "R11", sel_led, 0);
    @(posedge clk); #3; rst_n = 1; started = 1;

    access(32'hFF10_0000, 6'h09, 1, "R1");
    access(32'hFF1F_FFFC, 6'h0A, 1, "R1");
    access(32'hFF20_0000, 6'h09, 0, "R1");
    access(32'hFF0F_FFFC, 6'h0E, 0, "R1");
    access(32'h0015_0000, 6'h3D, 1, "R2");
    access(32'h1218_0000, 6'h39, 1, "R2");
    access(32'h0025_0000, 6'h3E, 0, "R2");

    cfg_a24_en = 0;
    access(32'h0015_0000, 6'h3D, 0, "R3");
    access(32'hFF15_0000, 6'h0D, 1, "R3");
    cfg_any_am = 1;
    access(32'hFF15_0000, 6'h3E, 0, "R3");
    cfg_any_am = 0; cfg_a24_en = 1;

    for (int i = 0; i < 10; i++) begin
      cfg_am_en = 10'(1 << i);
      access(32'hFF15_0000, codes[i], 1, "R4");
      access(32'hFF15_0000, codes[(i + 1) % 10], 0, "R4");
    end
    cfg_am_en = 10'h3FF;
    access(32'hFF15_0000, 6'h29, 0, "R5");
    access(32'hFF15_0000, 6'h2D, 0, "R5");
    access(32'hFF15_0000, 6'h0B, 0, "R5");
    access(32'hFF15_0000, 6'h0F, 0, "R5");
    access(32'hFF15_0000, 6'h3B, 0, "R5");
    access(32'hFF15_0000, 6'h3F, 0, "R5");

    cfg_any_am = 1; cfg_am_en = 10'h000;
    access(32'hFF15_0000, 6'h2D, 1, "R6");
    access(32'hFF15_0000, 6'h3F, 1, "R6");
    access(32'h0015_0000, 6'h3F, 0, "R6");
    access(32'h0015_0000, 6'h3A, 1, "R6");
    cfg_any_am = 0; cfg_am_en = 10'h0FF;

    run = 0;
    access(32'hFF15_0000, 6'h09, 0, "R7");
    run = 1;
    @(posedge clk); #3; addr = 32'hFF15_0000; am = 6'h09; as_n = 0; tag = "R7";
    @(posedge clk); @(negedge clk);
    chk(sel == 1, "R7 pre", sel, 1);
    @(posedge clk); #3; run = 0;
    @(posedge clk); @(negedge clk);
    chk(sel == 0, "R7", sel, 0);
    @(posedge clk); #3; as_n = 1; run = 1;
    idle(12);

    cfg_limit = cfg_start;
    access(32'hFF10_0000, 6'h09, 0, "R9");
    cfg_limit = 14'h0010;
    access(32'hFF10_0000, 6'h09, 0, "R9");
    access(32'h0000_0000, 6'h09, 0, "R9");
    cfg_limit = 14'h3FC8;
    idle(12);

    tag = "R10";
    @(posedge clk); #3; addr = 32'hFF18_0000; am = 6'h0D; as_n = 0;
    @(posedge clk); @(negedge clk);
    chk(sel_led == 1, "R10 on", sel_led, 1);
    @(posedge clk); #3; as_n = 1;
    @(posedge clk);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sel_led) n++;
    end
    chk(n == LED_HOLD, "R10 hold", n, LED_HOLD);

    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule